// File: doc/BRIEF.md
# Timer Channel Match Latch Controller

This block holds the match recognition state of one timer channel. There are two match slots. Each slot has a match register, an enable flag and a recognition latch. On every cycle, each enabled slot compares its match value against a free-running time base. A compare that succeeds sets the slot's latch and consumes the enable. While any latch is set, the block raises a service request to the channel scheduler.

The service routine drives the block through single-cycle command strobes that act on each slot:
- write a value into a slot and arm it;
- clear a slot's latch;
- switch match detection off for both slots.

A separate per-thread block input keeps the latches from being set, but only while a thread is active.

Simultaneous events resolve by fixed rules. These rules let a routine write a match time that is already past, or rewrite a register while its old match fires, without losing or duplicating a recognition. The match registers can be read back, so a routine can save a value before re-arming overwrites it.

Top module: `chan_match_ctl`

## Requirements
- R1: After a synchronous reset, every latch, enable flag and match register is zero, and the service request is low.
- R2: A write strobe for slot i loads the value bus into slot i's match register and sets slot i's enable at the same clock edge. The register appears on `match_val[i*24 +: 24]`. Slot 0 is slot A and slot 1 is slot B.
- R3: An enabled slot whose match value is less than or equal to the time base (unsigned compare) sets its latch and clears its enable at the next edge. A value already in the past therefore matches on the first compare after it is written.
- R4: If the old value matches in the same cycle that its register is rewritten, the latch is set and the enable stays set. The new value can then produce a later match, which clears the enable.
- R5: If a latch clear and a write for the same slot arrive in one cycle, the latch ends up clear and the enable set. After that, only the new value can set the latch.
- R6: A clear issued while the old compare is still enabled and satisfied is followed, one edge later, by the latch being set again. A clear issued after a past-due value has already matched loses that match: the latch and the enable both stay clear.
- R7: While the thread-active and thread-block inputs are both high, no latch is set and no enable changes because of a compare. A compare condition that ends before the thread ends leaves the latch clear. Blocking stops as soon as thread-active falls.
- R8: The detection-off strobe clears both enables. They stay clear, through thread end and through satisfied compares, until each slot is re-armed by its own write. A write in the same cycle as detection-off wins for that slot.
- R9: The service request is high whenever any latch is set. It stays high with no further stimulus, and falls only after the last set latch is explicitly cleared.
- R10: A clear in the same cycle as a hit on an unchanged register leaves the latch clear and the enable set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbase | input | 24 | Free-running time base |
| wr_val | input | 24 | Value bus for write-and-arm commands |
| wr_arm | input | 2 | Per-slot write-and-arm strobe |
| clr_latch | input | 2 | Per-slot latch clear strobe |
| det_off | input | 1 | Detection-off strobe, clears both enables |
| thr_active | input | 1 | A service thread is running |
| thr_block | input | 1 | Thread wants latches blocked while it runs |
| latch | output | 2 | Per-slot recognition latch |
| enable | output | 2 | Per-slot enable flag |
| match_val | output | 48 | Match registers, slot i at bits i*24 +: 24 |
| svc_req | output | 1 | Service request |

## Verification
The hardest condition to reach from the ports is a match on the old value in the very cycle its register is rewritten, so that the latch is set while the enable is left armed. The stimulus gets there by first arming a slot with a value below the time base that is about to be applied. It then raises the time base and pulses the rewrite in the same cycle. That armed-and-latched state is then reused to show that a lone clear is followed by a re-set one edge later. The same state, reached separately, shows that a clear issued together with the write suppresses the old hit.

// File: rtl/cm_pkg.sv
package cm_pkg;

    localparam int TB_W   = 24;
    localparam int N_SLOT = 2;

    typedef struct packed {
        logic wr;
        logic clr;
    } slot_cmd_t;

    typedef struct packed {
        logic latch;
        logic en;
    } slot_flags_t;

    function automatic logic reached(input logic [TB_W-1:0] now,
                                     input logic [TB_W-1:0] target);
        return now >= target;
    endfunction

endpackage

// File: rtl/cm_compare.sv
module cm_compare
    import cm_pkg::*;
(
    input  logic [TB_W-1:0] now,
    input  logic [TB_W-1:0] target,
    output logic            ge
);
    assign ge = reached(now, target);
endmodule

// File: rtl/cm_slot.sv
module cm_slot
    import cm_pkg::*;
#(
    parameter int TW = TB_W
) (
    input  logic          clk,
    input  logic          rst,
    input  slot_cmd_t     cmd,
    input  logic          det_off,
    input  logic          blk,
    input  logic [TW-1:0] tbase,
    input  logic [TW-1:0] wr_val,
    output slot_flags_t   flags,
    output logic [TW-1:0] val
);
    slot_flags_t   fl_q, fl_d;
    logic [TW-1:0] val_q, val_d;
    logic          ge;
    logic          hit;

    cm_compare u_cmp (
        .now    (tbase),
        .target (val_q),
        .ge     (ge)
    );

    // A hit needs an armed slot, an unblocked path and no clear this cycle.
    assign hit = fl_q.en & ge & ~blk & ~cmd.clr;

    always_comb begin
        fl_d  = fl_q;
        val_d = val_q;
        if (cmd.clr)  fl_d.latch = 1'b0;
        else if (hit) fl_d.latch = 1'b1;
        if (cmd.wr)       fl_d.en = 1'b1;
        else if (det_off) fl_d.en = 1'b0;
        else if (hit)     fl_d.en = 1'b0;
        if (cmd.wr) val_d = wr_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fl_q  <= '0;
            val_q <= '0;
        end else begin
            fl_q  <= fl_d;
            val_q <= val_d;
        end
    end

    assign flags = fl_q;
    assign val   = val_q;

    // R2
    a_r2_write_arms: assert property (@(posedge clk) disable iff (rst)
        cmd.wr |=> (fl_q.en && val_q == $past(wr_val)));
    // R3
    a_r3_hit_latches: assert property (@(posedge clk) disable iff (rst)
        (fl_q.en && ge && !blk && !cmd.clr) |=> fl_q.latch);
    a_r3_hit_consumes: assert property (@(posedge clk) disable iff (rst)
        (fl_q.en && ge && !blk && !cmd.clr && !cmd.wr) |=> !fl_q.en);
    // R4
    a_r4_rewrite_keeps_en: assert property (@(posedge clk) disable iff (rst)
        (fl_q.en && ge && !blk && !cmd.clr && cmd.wr) |=> (fl_q.latch && fl_q.en));
    // R10 / R5
    a_r10_clear_wins: assert property (@(posedge clk) disable iff (rst)
        cmd.clr |=> !fl_q.latch);
    // R7
    a_r7_block_holds: assert property (@(posedge clk) disable iff (rst)
        (blk && !fl_q.latch && !cmd.clr) |=> !fl_q.latch);
    // R8
    a_r8_det_off: assert property (@(posedge clk) disable iff (rst)
        (det_off && !cmd.wr) |=> !fl_q.en);
    // R9
    a_r9_latch_sticky: assert property (@(posedge clk) disable iff (rst)
        (fl_q.latch && !cmd.clr) |=> fl_q.latch);
endmodule

// File: rtl/cm_req.sv
module cm_req
    import cm_pkg::*;
#(
    parameter int N = N_SLOT
) (
    input  logic [N-1:0] latches,
    output logic         req
);
    assign req = |latches;
endmodule

// File: rtl/chan_match_ctl.sv
module chan_match_ctl
    import cm_pkg::*;
#(
    parameter int TW = TB_W,
    parameter int N  = N_SLOT,
    localparam int VW = TW * N
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] tbase,
    input  logic [TW-1:0] wr_val,
    input  logic [N-1:0]  wr_arm,
    input  logic [N-1:0]  clr_latch,
    input  logic          det_off,
    input  logic          thr_active,
    input  logic          thr_block,
    output logic [N-1:0]  latch,
    output logic [N-1:0]  enable,
    output logic [VW-1:0] match_val,
    output logic          svc_req
);
    logic blk;
    assign blk = thr_active & thr_block;

    for (genvar i = 0; i < N; i++) begin : g_slot
        slot_cmd_t   cmd;
        slot_flags_t fl;
        assign cmd.wr  = wr_arm[i];
        assign cmd.clr = clr_latch[i];

        cm_slot #(.TW(TW)) u_slot (
            .clk     (clk),
            .rst     (rst),
            .cmd     (cmd),
            .det_off (det_off),
            .blk     (blk),
            .tbase   (tbase),
            .wr_val  (wr_val),
            .flags   (fl),
            .val     (match_val[i*TW +: TW])
        );
        assign latch[i]  = fl.latch;
        assign enable[i] = fl.en;
    end

    cm_req #(.N(N)) u_req (
        .latches (latch),
        .req     (svc_req)
    );

    // R9: the request can only fall after a clear strobe.
    a_r9_req_falls_on_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(svc_req) |-> $past(|clr_latch));
endmodule

// File: tb/chan_match_ctl_test.sv
`timescale 1ns/1ps
module chan_match_ctl_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [23:0] tbase;
    logic [23:0] wr_val;
    logic [1:0]  wr_arm;
    logic [1:0]  clr_latch;
    logic        det_off;
    logic        thr_active;
    logic        thr_block;
    logic [1:0]  latch;
    logic [1:0]  enable;
    logic [47:0] match_val;
    logic        svc_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    chan_match_ctl uut (
        .clk(clk), .rst(rst), .tbase(tbase), .wr_val(wr_val),
        .wr_arm(wr_arm), .clr_latch(clr_latch), .det_off(det_off),
        .thr_active(thr_active), .thr_block(thr_block),
        .latch(latch), .enable(enable), .match_val(match_val),
        .svc_req(svc_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One clock edge; inputs were set at a falling edge, strobes drop after.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        wr_arm    = '0;
        clr_latch = '0;
        det_off   = 1'b0;
    endtask

    function automatic logic [23:0] mv(input int s);
        return match_val[s*24 +: 24];
    endfunction

    task automatic arm(input int s, input logic [23:0] v);
        wr_arm[s] = 1'b1;
        wr_val    = v;
        step();
    endtask

    task automatic clear_all();
        clr_latch = 2'b11;
        step();
    endtask

    task automatic t_reset();
        chk("R1 latch", latch, 0);
        chk("R1 enable", enable, 0);
        chk("R1 match_val", match_val[31:0], 0);
        chk("R1 svc_req", svc_req, 0);
    endtask

    task automatic t_write_compare();
        tbase = 100;
        arm(0, 200);
        chk("R2 enable A", enable[0], 1);
        chk("R2 readback A", mv(0), 200);
        tbase = 150; step();
        chk("R3 no early hit", latch[0], 0);
        tbase = 200; step();
        chk("R3 equal hits latch", latch[0], 1);
        chk("R3 enable consumed", enable[0], 0);
        chk("R9 req on latch", svc_req, 1);
        clear_all();
        chk("R9 req drops on clear", svc_req, 0);
        tbase = 500;
        arm(1, 300);
        chk("R2 enable B", enable[1], 1);
        chk("R2 readback B", mv(1), 300);
        step();
        chk("R3 past-due matches", latch[1], 1);
        chk("R3 past-due enable", enable[1], 0);
        clear_all();
    endtask

    task automatic t_coincident();
        tbase = 100;
        arm(0, 400);
        tbase = 450; wr_arm[0] = 1'b1; wr_val = 600; step();
        chk("R4 old match latched", latch[0], 1);
        chk("R4 enable kept", enable[0], 1);
        chk("R4 new value", mv(0), 600);
        tbase = 599; step();
        chk("R4 still armed", enable[0], 1);
        tbase = 600; step();
        chk("R4 new match consumes", enable[0], 0);
        chk("R4 latch held", latch[0], 1);
        clear_all();
    endtask

    task automatic t_clr_write();
        tbase = 100;
        arm(0, 300);
        tbase = 350; clr_latch[0] = 1'b1; wr_arm[0] = 1'b1; wr_val = 800; step();
        chk("R5 latch clear", latch[0], 0);
        chk("R5 armed", enable[0], 1);
        tbase = 700; step();
        chk("R5 old value ignored", latch[0], 0);
        tbase = 800; step();
        chk("R5 new value hits", latch[0], 1);
        clear_all();
    endtask

    task automatic t_early_late_clear();
        tbase = 50;
        arm(0, 100);
        tbase = 200; wr_arm[0] = 1'b1; wr_val = 150; step();
        chk("R6 setup latch", latch[0], 1);
        chk("R6 setup enable", enable[0], 1);
        clr_latch[0] = 1'b1; step();
        chk("R10 clear beats hit", latch[0], 0);
        chk("R10 enable kept", enable[0], 1);
        step();
        chk("R6 early clear re-set", latch[0], 1);
        chk("R6 re-set consumes", enable[0], 0);
        clear_all();
        arm(0, 100);
        step();
        chk("R6 late setup", latch[0], 1);
        clr_latch[0] = 1'b1; step();
        step(); step();
        chk("R6 late clear loses match", latch[0], 0);
        chk("R6 late clear enable", enable[0], 0);
        chk("R6 no request", svc_req, 0);
    endtask

    task automatic t_thread_block();
        tbase = 0;
        arm(1, 1000);
        thr_active = 1; thr_block = 1; tbase = 1200; step();
        chk("R7 blocked latch", latch[1], 0);
        chk("R7 blocked enable", enable[1], 1);
        tbase = 900; step();
        thr_active = 0; thr_block = 0; step();
        chk("R7 transient left clear", latch[1], 0);
        thr_active = 1; thr_block = 1; tbase = 1100; step();
        chk("R7 blocked again", latch[1], 0);
        thr_active = 0; step();
        chk("R7 block ends with thread", latch[1], 1);
        thr_block = 0;
        clear_all();
    endtask

    task automatic t_det_off();
        tbase = 0;
        arm(0, 5000);
        arm(1, 6000);
        thr_active = 1; det_off = 1'b1; step();
        chk("R8 both disabled", enable, 0);
        thr_active = 0; tbase = 7000; step(); step();
        chk("R8 no latch after thread", latch, 0);
        chk("R8 stays disabled", enable, 0);
        arm(0, 5000);
        chk("R8 only A re-armed", enable, 2'b01);
        step();
        chk("R8 A matches, B idle", latch, 2'b01);
        det_off = 1'b1; wr_arm[1] = 1'b1; wr_val = 8000; step();
        chk("R8 write wins over det_off", enable[1], 1);
        clear_all();
    endtask

    task automatic t_request();
        tbase = 10;
        wr_arm = 2'b11; wr_val = 5; step();
        step();
        chk("R9 both latched", latch, 2'b11);
        step(); step(); step();
        chk("R9 request holds", svc_req, 1);
        clr_latch[0] = 1'b1; step();
        chk("R9 one latch keeps request", svc_req, 1);
        clr_latch[1] = 1'b1; step();
        chk("R9 request falls", svc_req, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst = 1; tbase = 0; wr_val = 0; wr_arm = 0; clr_latch = 0;
        det_off = 0; thr_active = 0; thr_block = 0;
        @(negedge clk); @(negedge clk);
        rst = 0;
        t_reset();
        t_write_compare();
        t_coincident();
        t_clr_write();
        t_early_late_clear();
        t_thread_block();
        t_det_off();
        t_request();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule